// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block sits between an internal valid/ready request port and an external asynchronous memory bus of the kind used by SRAM, NOR flash and NAND flash parts. Each accepted request becomes one external access. The two most significant request address bits pick one of four chip-select windows of 64 MiB each, so the controller covers 256 MiB in total. The remaining bits go out unchanged as the device address.

Every chip select holds its own timing word, written through a small configuration port. The word gives the read and write setup, strobe and hold lengths in controller clock cycles, and a turnaround gap. It also carries two mode bits. In select-strobe mode the chip select behaves as a strobe and is asserted only while output enable or write enable is active. In extended-wait mode the strobe is stretched for as long as the wait line of that chip select, once synchronized, stays high. Read data is captured on the final strobe cycle and returned with a single-cycle response pulse.

Top module: `async_mem_ctrl`

## Requirements
- R1: Request address bits [27:26] select the chip select: value k drives `mem_cs_n[k]` low and no other select. Bits [25:0] appear on `mem_addr` for the whole access.
- R2: A read runs a setup phase, then a strobe phase with `mem_oe_n` low, then a hold phase. The phases last the read setup, read strobe and read hold counts of that chip select, and the chip select stays low through all three.
- R3: A write has the same three phases, driven by the write setup, write strobe and write hold counts, with `mem_we_n` low in the strobe. `mem_addr` and `mem_dout` stay stable from the first setup cycle to the last hold cycle.
- R4: A programmed setup, strobe or hold count of zero behaves exactly like a count of one.
- R5: If a request is waiting when an access ends, `mem_cs_n` stays all high for 1 + T cycles before the next access. T is the turnaround field of the new access's chip select.
- R6: The turnaround field is not applied (gap of one cycle) when the new access has the same chip select and the same direction as the previous one.
- R7: With the select-strobe bit set, the chip select is low only during strobe cycles.
- R8: With the extended-wait bit set, `mem_wait[k]` passes through a two-stage synchronizer. If wait is high before the strobe starts and falls during strobe cycle j, the strobe lasts max(S, j+2) cycles, where S is the programmed strobe count.
- R9: A chip select whose extended-wait bit is clear ignores its wait line. Wait lines of other chip selects never affect an access.
- R10: `req_ready` is high only while idle. A request is taken on a clock edge with `req_valid` and `req_ready` both high, and `req_ready` stays low for the whole access.
- R11: For a read, `rsp_rdata` holds the `mem_din` value from the last strobe cycle, and `rsp_valid` is high for exactly one cycle, the first hold cycle.
- R12: A cycle with `cfg_we` high writes `cfg_data` into the timing word of chip select `cfg_sel`, and only that one. Field layout: [3:0] read setup, [9:4] read strobe, [13:10] read hold, [17:14] write setup, [23:18] write strobe, [27:24] write hold, [30:28] turnaround, [31] select-strobe, [32] extended-wait.
- R13: After reset, every chip select, `mem_oe_n` and `mem_we_n` is high, `req_ready` is high and `rsp_valid` is low. All timing words read as zero.
- R14: At most one chip select is low at a time, and `mem_oe_n` and `mem_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_sel | input | 2 | Chip select whose timing word is written |
| cfg_data | input | 33 | Timing word value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Byte address in the 256 MiB external space |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 16 | Read data |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable (read strobe) |
| mem_we_n | output | 1 | Active-low write enable (write strobe) |
| mem_addr | output | 26 | Device address within the window |
| mem_dout | output | 16 | Data driven to the device |
| mem_din | input | 16 | Data returned by the device |
| mem_wait | input | 4 | Per-select wait request from the device |

## Verification
The bench measures every phase length, and the idle gap between accesses, from the external pins. This catches a design that loads counts off by one, runs zero as a zero-length phase, or applies turnaround to back-to-back same-direction accesses, since each of those moves an edge by a cycle. Wait lines are dropped at chosen strobe cycles. A design without the synchronizer, or one that samples wait in the wrong phase, ends the strobe too early, and a design that reads the wrong wait bit or ignores the mode bit stretches accesses that should not stretch. Select-strobe windows and the response pulse position are also checked, so a chip select held through setup and hold, or data captured after the strobe, shows up as a mismatch.

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl #(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 4,
  parameter int SET_W  = 4,
  parameter int STB_W  = 6,
  parameter int TA_W   = 3,
  localparam int CS_BITS = $clog2(NUM_CS),
  localparam int LOC_W   = ADDR_W - CS_BITS,
  localparam int CFG_W   = 4 * SET_W + 2 * STB_W + TA_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CS_BITS-1:0] cfg_sel,
  input  logic [CFG_W-1:0]   cfg_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [NUM_CS-1:0]  mem_cs_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [LOC_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]  mem_dout,
  input  logic [DATA_W-1:0]  mem_din,
  input  logic [NUM_CS-1:0]  mem_wait
);

  localparam int RS_LO  = 0;
  localparam int RT_LO  = RS_LO + SET_W;
  localparam int RH_LO  = RT_LO + STB_W;
  localparam int WS_LO  = RH_LO + SET_W;
  localparam int WT_LO  = WS_LO + SET_W;
  localparam int WH_LO  = WT_LO + STB_W;
  localparam int TA_LO  = WH_LO + SET_W;
  localparam int SS_BIT = TA_LO + TA_W;
  localparam int EW_BIT = SS_BIT + 1;
  localparam int CNT_A  = (STB_W > SET_W) ? STB_W : SET_W;
  localparam int CNT_W  = (CNT_A > TA_W) ? CNT_A : TA_W;

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_SETUP, S_STRB, S_HOLD} st_e;

  st_e                st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   lim;
  logic [CS_BITS-1:0] cs_q, prev_cs_q;
  logic               wr_q, prev_wr_q, prev_vld_q, rsp_q;
  logic [LOC_W-1:0]   addr_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;
  logic [NUM_CS-1:0]  wsync1_q, wsync2_q;
  logic [CFG_W-1:0]   cfg_q [NUM_CS];

  function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [CS_BITS-1:0] req_cs;
  logic [CFG_W-1:0]   cur_cfg;
  logic [TA_W-1:0]    new_ta;
  logic               same_kind, do_turn, wait_hold, in_cycle, cs_on, phase_done;

  assign req_cs     = req_addr[ADDR_W-1 -: CS_BITS];
  assign cur_cfg    = cfg_q[cs_q];
  assign new_ta     = cfg_q[req_cs][TA_LO +: TA_W];
  assign same_kind  = prev_vld_q && (prev_cs_q == req_cs) && (prev_wr_q == req_write);
  assign do_turn    = prev_vld_q && !same_kind && (new_ta != '0);
  assign wait_hold  = cur_cfg[EW_BIT] && wsync2_q[cs_q];
  assign in_cycle   = (st_q == S_SETUP) || (st_q == S_STRB) || (st_q == S_HOLD);
  assign cs_on      = cur_cfg[SS_BIT] ? (st_q == S_STRB) : in_cycle;
  assign phase_done = (cnt_q == lim);

  always_comb begin
    unique case (st_q)
      S_TURN:  lim = CNT_W'(cur_cfg[TA_LO +: TA_W]) - 1'b1;
      S_SETUP: lim = len_m1(wr_q ? CNT_W'(cur_cfg[WS_LO +: SET_W]) : CNT_W'(cur_cfg[RS_LO +: SET_W]));
      S_STRB:  lim = len_m1(wr_q ? CNT_W'(cur_cfg[WT_LO +: STB_W]) : CNT_W'(cur_cfg[RT_LO +: STB_W]));
      S_HOLD:  lim = len_m1(wr_q ? CNT_W'(cur_cfg[WH_LO +: SET_W]) : CNT_W'(cur_cfg[RH_LO +: SET_W]));
      default: lim = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) cfg_q[i] <= '0;
    end else if (cfg_we) begin
      cfg_q[cfg_sel] <= cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsync1_q <= '0;
      wsync2_q <= '0;
    end else begin
      wsync1_q <= mem_wait;
      wsync2_q <= wsync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cnt_q      <= '0;
      cs_q       <= '0;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      rsp_q      <= 1'b0;
      prev_cs_q  <= '0;
      prev_wr_q  <= 1'b0;
      prev_vld_q <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_valid) begin
          cs_q    <= req_cs;
          wr_q    <= req_write;
          addr_q  <= req_addr[LOC_W-1:0];
          wdata_q <= req_wdata;
          cnt_q   <= '0;
          st_q    <= do_turn ? S_TURN : S_SETUP;
        end
        S_TURN: if (phase_done) begin
          cnt_q <= '0;
          st_q  <= S_SETUP;
        end else cnt_q <= cnt_q + 1'b1;
        S_SETUP: if (phase_done) begin
          cnt_q <= '0;
          st_q  <= S_STRB;
        end else cnt_q <= cnt_q + 1'b1;
        S_STRB: if (!phase_done) cnt_q <= cnt_q + 1'b1;
        else if (!wait_hold) begin
          cnt_q <= '0;
          st_q  <= S_HOLD;
          if (!wr_q) begin
            rdata_q <= mem_din;
            rsp_q   <= 1'b1;
          end
        end
        S_HOLD: if (phase_done) begin
          st_q       <= S_IDLE;
          prev_cs_q  <= cs_q;
          prev_wr_q  <= wr_q;
          prev_vld_q <= 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
    assign mem_cs_n[k] = !(cs_on && (cs_q == CS_BITS'(k)));
  end

  assign req_ready = (st_q == S_IDLE);
  assign mem_oe_n  = !((st_q == S_STRB) && !wr_q);
  assign mem_we_n  = !((st_q == S_STRB) && wr_q);
  assign mem_addr  = addr_q;
  assign mem_dout  = wdata_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/async_mem_ctrl_chk.sv
module async_mem_ctrl_chk #(
  parameter int NUM_CS = 4,
  parameter int LOC_W  = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [NUM_CS-1:0] mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LOC_W-1:0]  mem_addr
);

  p_one_cs_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  p_strobe_excl_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  p_strobe_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n));

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&mem_cs_n) && $past(!(&mem_cs_n))) |-> $stable(mem_addr));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_no_ready_in_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(&mem_cs_n) |-> !req_ready);

endmodule

bind async_mem_ctrl async_mem_ctrl_chk #(.NUM_CS(NUM_CS), .LOC_W(LOC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_addr(mem_addr)
);

// File: tb/async_mem_ctrl_bench.sv
module async_mem_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LOC_W = 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [32:0] cfg_data = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready, rsp_valid;
  logic [27:0] req_addr = '0;
  logic [15:0] req_wdata = '0, rsp_rdata, mem_dout, mem_din;
  logic [3:0]  mem_cs_n, mem_wait, wait_mask = '0;
  logic        mem_oe_n, mem_we_n;
  logic [LOC_W-1:0] mem_addr;

  int checks = 0, fails = 0, cyc = 0, scount = 0, rel_at = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_din  = mem_addr[15:0] ^ 16'h5A3C;
  assign mem_wait = (rel_at == 0 || scount < rel_at) ? wait_mask : 4'b0;

  async_mem_ctrl u_async_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_din(mem_din), .mem_wait(mem_wait)
  );

  typedef struct {
    bit wr; int cs; logic [LOC_W-1:0] addr; logic [15:0] wd;
    int pre, strb, post, gap; bit rsp_chk; string tag;
  } exp_t;

  exp_t        expq[$];
  logic [15:0] rq[$];

  int rs[4], rt[4], rh[4], ws[4], wt[4], wh[4], ta[4], ss[4], ew[4];
  bit have_prev = 0, prev_wr = 0, prev_ss = 0, gap_known = 0;
  int prev_cs = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic set_cfg(input int c, input int a_rs, input int a_rt, input int a_rh,
                         input int a_ws, input int a_wt, input int a_wh, input int a_ta,
                         input int a_ss, input int a_ew);
    rs[c] = a_rs; rt[c] = a_rt; rh[c] = a_rh; ws[c] = a_ws; wt[c] = a_wt;
    wh[c] = a_wh; ta[c] = a_ta; ss[c] = a_ss; ew[c] = a_ew;
    cfg_we   = 1'b1;
    cfg_sel  = 2'(c);
    cfg_data = {1'(a_ew), 1'(a_ss), 3'(a_ta), 4'(a_wh), 6'(a_wt), 4'(a_ws),
                4'(a_rh), 6'(a_rt), 4'(a_rs)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input bit wr, input int c, input int loc, input int wd,
                       input int rel, input string tag);
    exp_t e;
    int s;
    e.wr = wr; e.cs = c; e.addr = LOC_W'(loc); e.wd = 16'(wd); e.tag = tag;
    s = wr ? eff(wt[c]) : eff(rt[c]);
    if (ew[c] != 0 && rel > 0 && s < rel + 2) s = rel + 2;
    e.strb = s;
    e.pre  = (ss[c] != 0) ? 0 : eff(wr ? ws[c] : rs[c]);
    e.post = (ss[c] != 0) ? 0 : eff(wr ? wh[c] : rh[c]);
    if (!gap_known || !have_prev || prev_ss || ss[c] != 0) e.gap = -1;
    else if (prev_cs == c && prev_wr == wr) e.gap = 1;
    else e.gap = 1 + ta[c];
    e.rsp_chk = !wr && ss[c] == 0;
    expq.push_back(e);
    if (!wr) rq.push_back(16'(loc) ^ 16'h5A3C);
    have_prev = 1; prev_cs = c; prev_wr = wr; prev_ss = (ss[c] != 0); gap_known = 1;
    rel_at    = rel;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {2'(c), LOC_W'(loc)};
    req_wdata = 16'(wd);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0 || rq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    gap_known = 0;
  endtask

  bit in_win = 0, w_wr = 0, w_rsp1 = 0, w_ready = 0, w_unstable = 0;
  int w_cs = 0, w_pre = 0, w_strb = 0, w_post = 0, w_gap = 0, last_end = 0;
  logic [LOC_W-1:0] w_addr, a0;
  logic [15:0] w_wd, d0;

  initial forever begin
    @(negedge clk);
    cyc++;
    if (!rst_n) continue;
    if (!mem_oe_n || !mem_we_n) scount++; else scount = 0;
    if (!(&mem_cs_n)) begin
      if (!in_win) begin
        in_win = 1; w_pre = 0; w_strb = 0; w_post = 0; w_rsp1 = 0;
        w_ready = 0; w_unstable = 0; w_gap = cyc - last_end;
        a0 = mem_addr; d0 = mem_dout;
      end
      if (mem_addr !== a0 || mem_dout !== d0) w_unstable = 1;
      if (req_ready) w_ready = 1;
      if (!mem_oe_n || !mem_we_n) begin
        w_strb++;
        if (w_strb == 1) begin
          w_wr = !mem_we_n; w_addr = mem_addr; w_wd = mem_dout;
          for (int i = 0; i < 4; i++) if (!mem_cs_n[i]) w_cs = i;
        end
      end else if (w_strb == 0) w_pre++;
      else begin
        w_post++;
        if (w_post == 1) w_rsp1 = rsp_valid;
      end
    end else if (in_win) begin
      in_win = 0;
      last_end = cyc;
      if (expq.size() == 0) chk(0, "R10 unexpected access", 1, 0);
      else begin
        exp_t e;
        e = expq.pop_front();
        chk(w_cs == e.cs, {"R1 chip select ", e.tag}, w_cs, e.cs);
        chk(w_addr == e.addr, {"R1 address ", e.tag}, int'(w_addr), int'(e.addr));
        chk(w_wr == e.wr, {"R14 strobe kind ", e.tag}, w_wr, e.wr);
        chk(w_pre == e.pre, {"setup length ", e.tag}, w_pre, e.pre);
        chk(w_strb == e.strb, {"strobe length ", e.tag}, w_strb, e.strb);
        chk(w_post == e.post, {"hold length ", e.tag}, w_post, e.post);
        chk(!w_unstable, {"R3 address/data stable ", e.tag}, w_unstable, 0);
        chk(!w_ready, {"R10 ready low in access ", e.tag}, w_ready, 0);
        if (e.wr) chk(w_wd == e.wd, {"R3 write data ", e.tag}, int'(w_wd), int'(e.wd));
        if (e.gap >= 0) chk(w_gap == e.gap, {"R5/R6 idle gap ", e.tag}, w_gap, e.gap);
        if (e.rsp_chk) chk(w_rsp1, {"R11 response in first hold cycle ", e.tag}, w_rsp1, 1);
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (rst_n && rsp_valid) begin
      if (rq.size() == 0) chk(0, "R11 unexpected response", 1, 0);
      else begin
        logic [15:0] x;
        x = rq.pop_front();
        chk(rsp_rdata == x, "R11 read data", int'(rsp_rdata), int'(x));
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    report();
  end

  initial begin
    for (int i = 0; i < 4; i++) set_zero(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(mem_cs_n == 4'hF, "R13 chip selects idle", int'(mem_cs_n), 15);
    chk(mem_oe_n && mem_we_n, "R13 strobes idle", {mem_oe_n, mem_we_n}, 3);
    chk(req_ready, "R13 ready after reset", req_ready, 1);
    chk(!rsp_valid, "R13 no response after reset", rsp_valid, 0);

    // R4 and R13: all-zero timing words give one-cycle phases
    issue(0, 0, 'h123, 0, 0, "R4 zero word read");
    issue(1, 1, 'h456, 'hBEEF, 0, "R4 zero word write");
    drain();

    // R12 distinct timing words per chip select
    set_cfg(0, 2, 3, 1, 1, 4, 2, 3, 0, 0);
    set_cfg(1, 3, 5, 2, 2, 2, 3, 5, 0, 0);
    set_cfg(2, 2, 3, 2, 1, 2, 1, 2, 1, 0);
    set_cfg(3, 1, 2, 1, 1, 3, 1, 0, 0, 1);

    issue(0, 0, 'h10, 0, 0, "R2 R12 read cs0");
    issue(0, 0, 'h11, 0, 0, "R6 read after read");
    issue(1, 0, 'h12, 'h1111, 0, "R5 write after read");
    issue(1, 0, 'h13, 'h2222, 0, "R6 write after write");
    issue(0, 1, 'h200, 0, 0, "R5 read on new select");
    issue(0, 1, 'h201, 0, 0, "R6 read after read cs1");
    issue(1, 1, 'h202, 'h3333, 0, "R3 write cs1");
    issue(0, 0, 'h14, 0, 0, "R5 turnaround of cs0");
    issue(0, 3, 'h3FFFFFF, 0, 0, "R1 top of window cs3");
    issue(1, 3, 'h2AAAAAA, 'h4444, 0, "R5 zero turnaround");
    issue(0, 2, 'h777, 0, 0, "R7 select-strobe read");
    issue(1, 2, 'h778, 'h5555, 0, "R7 select-strobe write");
    issue(0, 0, 'h15, 0, 0, "R2 read after strobe mode");
    drain();

    // R8 extended wait: wait falls in strobe cycle rel
    wait_mask = 4'b1000;
    issue(0, 3, 'h40, 0, 4, "R8 read stretched");
    drain();
    issue(1, 3, 'h41, 'h6666, 2, "R8 write stretched");
    drain();
    issue(1, 3, 'h42, 'h7777, 1, "R8 early release");
    drain();
    wait_mask = 4'b0;

    // R9 wait ignored when mode off or on another select
    wait_mask = 4'b0001;
    issue(0, 0, 'h50, 0, 0, "R9 wait ignored mode off");
    drain();
    issue(0, 3, 'h51, 0, 0, "R9 other select wait");
    drain();
    wait_mask = 4'b0;

    // R4 zero fields on a reconfigured select, R12 rewrite
    set_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    issue(1, 1, 'h60, 'h8888, 0, "R4 zeroed write");
    issue(0, 1, 'h61, 0, 0, "R4 zeroed read");
    issue(0, 0, 'h62, 0, 0, "R12 cs0 word untouched");
    drain();
    report();
  end

  task automatic set_zero(input int c);
    rs[c] = 0; rt[c] = 0; rh[c] = 0; ws[c] = 0; wt[c] = 0;
    wh[c] = 0; ta[c] = 0; ss[c] = 0; ew[c] = 0;
  endtask

endmodule